// File: doc/BRIEF.md
# Receive FIFO Interrupt Controller

This block generates the receive-side interrupts of a serial port that has a receive FIFO. It watches the FIFO fill level against a programmed threshold and raises a data-available request. It passes an external receive-error flag on as a line-status request. It runs a character-time timer that flags data left sitting in the FIFO when neither the line nor the CPU has touched it for a set number of character times. It also keeps a data-ready status bit. The requests are ranked, and a four-bit identification code tells the interrupt handler which source to service first.

The FIFO storage, the receive shift register and the baud-rate generator sit outside the block. They supply the fill level, a one-cycle strobe for each character written into the FIFO, a one-cycle strobe for each CPU read of the FIFO, and a one-cycle tick once per character time. The character-time tick is derived from the receive clock, so the timeout scales with the baud rate. When two stop bits are in use, that period includes the second stop bit.

Top module: `rxirq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge, and `int_id` reads 4'h1 (nothing pending).
- R2: With both receive enables set, `avail_irq` goes high at the edge that samples `fifo_level >= trig_level`, and goes low at the edge that samples `fifo_level < trig_level`.
- R3: While `fifo_en` or `rx_ie` is low, `avail_irq` and `tmo_irq` stay low at every edge.
- R4: `ls_irq` equals `rx_err && ls_ie` as sampled at the previous edge.
- R5: `int_id` is 4'h6 when `ls_irq` is high. Otherwise it is 4'h4 when `avail_irq` is high. Otherwise it is 4'hC when `tmo_irq` is high. Otherwise it is 4'h1. `irq` is high exactly when `int_id` is not 4'h1.
- R6: `data_ready` goes high at the edge that samples `rx_push`. It stays high while the sampled `fifo_level` is nonzero. It goes low at an edge that samples `fifo_level == 0` with no `rx_push`; `rx_push` wins if both are seen at the same edge.
- R7: With the enables set and the FIFO non-empty, `tmo_irq` goes high at the edge that samples the fourth `char_tick` since the timer last restarted. Three ticks are not enough.
- R8: While no timeout is pending, an `rx_push` or a `cpu_pop` restarts the timer, so four more ticks are needed.
- R9: A pending timeout is cleared at the edge that samples one `cpu_pop`, which also restarts the timer. An `rx_push` alone leaves it pending.
- R10: While `fifo_level` is zero, the timer is held at its start and `tmo_irq` stays low, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_ie | input | 1 | Receive data interrupt enable |
| ls_ie | input | 1 | Line-status interrupt enable |
| trig_level | input | 5 | Programmed fill threshold |
| fifo_level | input | 5 | Current FIFO occupancy |
| rx_push | input | 1 | Strobe: a character entered the FIFO |
| cpu_pop | input | 1 | Strobe: the CPU read one character |
| rx_err | input | 1 | Receive error flag held by the line-status logic |
| char_tick | input | 1 | One pulse per character time |
| data_ready | output | 1 | Data-ready status bit |
| avail_irq | output | 1 | Data-available request |
| ls_irq | output | 1 | Line-status request |
| tmo_irq | output | 1 | Character-timeout request |
| irq | output | 1 | Any request pending |
| int_id | output | 4 | Highest-priority pending source code |

## Verification
Every registered result of this block is due at the single clock edge that samples its stimulus. The level, strobes, error flag and tick all act through one register stage, and `int_id` and `irq` decode those registers without another stage. The driver sets inputs on the falling edge and queues the outputs it expects after the next rising edge. The monitor pops that entry two nanoseconds after the rising edge. This keeps each comparison to one edge of latency and clear of the edge itself. For timeouts, the driver counts ticks step by step, so the third tick is checked low and the fourth is checked high.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    // Identification codes, fixed encodings read by software
    typedef enum logic [3:0] {
        ID_NONE = 4'h1,
        ID_DATA = 4'h4,
        ID_LINE = 4'h6,
        ID_TMO  = 4'hC
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic data;
        logic tmo;
    } pend_t;

    // Rank: line status first, then data available, then timeout
    function automatic irq_id_e pick_id(pend_t p);
        irq_id_e r;
        if (p.line)      r = ID_LINE;
        else if (p.data) r = ID_DATA;
        else if (p.tmo)  r = ID_TMO;
        else             r = ID_NONE;
        return r;
    endfunction

    function automatic logic any_pend(pend_t p);
        return p.line | p.data | p.tmo;
    endfunction

endpackage

// File: rtl/rxirq_trigger.sv
module rxirq_trigger #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] trig,
    output logic          avail_o
);
    logic avail_q;

    always_ff @(posedge clk) begin
        if (rst) avail_q <= 1'b0;
        else     avail_q <= en && (level >= trig);
    end

    assign avail_o = avail_q;

    // R2
    avail_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (level < trig) |=> !avail_q);

endmodule

// File: rtl/rxirq_timer.sv
module rxirq_timer #(
    parameter int LW       = 5,
    parameter int TO_CHARS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [LW-1:0] level,
    input  logic          push,
    input  logic          pop,
    input  logic          tick,
    output logic          tmo_o
);
    localparam int CW = $clog2(TO_CHARS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          flag_q, flag_nxt;
    logic          empty, restart;

    always_comb begin
        empty   = (level == '0);
        // a push only restarts while no timeout is pending
        restart = pop || (push && !flag_q) || empty;
        if (restart)
            cnt_nxt = '0;
        else if (tick && (cnt_q != LIMIT))
            cnt_nxt = cnt_q + 1'b1;
        else
            cnt_nxt = cnt_q;

        if (!en || pop || empty)
            flag_nxt = 1'b0;
        else if (cnt_nxt == LIMIT)
            flag_nxt = 1'b1;
        else
            flag_nxt = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            flag_q <= flag_nxt;
        end
    end

    assign tmo_o = flag_q;

    // R9
    tmo_pop_clr_chk: assert property (@(posedge clk) disable iff (rst)
        pop |=> !flag_q);

    // R10
    tmo_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |=> (!flag_q && cnt_q == '0));

    // R7
    cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

endmodule

// File: rtl/rxirq_prio.sv
module rxirq_prio
    import rxirq_pkg::*;
(
    input  pend_t      pend,
    output logic [3:0] id_o,
    output logic       irq_o
);
    irq_id_e id;

    always_comb begin
        id    = pick_id(pend);
        irq_o = any_pend(pend);
    end

    assign id_o = id;

endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl
    import rxirq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4,
    parameter int LW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          rx_ie,
    input  logic          ls_ie,
    input  logic [LW-1:0] trig_level,
    input  logic [LW-1:0] fifo_level,
    input  logic          rx_push,
    input  logic          cpu_pop,
    input  logic          rx_err,
    input  logic          char_tick,
    output logic          data_ready,
    output logic          avail_irq,
    output logic          ls_irq,
    output logic          tmo_irq,
    output logic          irq,
    output logic [3:0]    int_id
);
    logic  rx_en;
    logic  rdy_q, ls_q;
    pend_t pend;

    assign rx_en = fifo_en && rx_ie;

    rxirq_trigger #(.LW(LW)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .en      (rx_en),
        .level   (fifo_level),
        .trig    (trig_level),
        .avail_o (avail_irq)
    );

    rxirq_timer #(.LW(LW), .TO_CHARS(TO_CHARS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .en    (rx_en),
        .level (fifo_level),
        .push  (rx_push),
        .pop   (cpu_pop),
        .tick  (char_tick),
        .tmo_o (tmo_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
            ls_q  <= 1'b0;
        end else begin
            if (rx_push)                 rdy_q <= 1'b1;
            else if (fifo_level == '0)   rdy_q <= 1'b0;
            ls_q <= rx_err && ls_ie;
        end
    end

    assign data_ready = rdy_q;
    assign ls_irq     = ls_q;

    assign pend = '{line: ls_q, data: avail_irq, tmo: tmo_irq};

    rxirq_prio u_prio (
        .pend  (pend),
        .id_o  (int_id),
        .irq_o (irq)
    );

    // R6
    rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_ready && fifo_level != '0) |=> data_ready);

    // R3
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !(fifo_en && rx_ie) |=> (!avail_irq && !tmo_irq));

    // R4
    ls_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_err && ls_ie) |=> ls_irq);

    // R5
    line_first_chk: assert property (@(posedge clk) disable iff (rst)
        ls_irq |-> (int_id == 4'h6 && irq));

endmodule

// File: tb/rxirq_ctrl_tb.sv
module rxirq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fen = 1'b1, rie = 1'b1, lie = 1'b1;
    logic [4:0] trig = 5'd4;
    logic [4:0] lvl = '0;
    logic       push = 1'b0, pop = 1'b0, err = 1'b0, tick = 1'b0;
    logic       rdy, av, ls, tmo, irq;
    logic [3:0] id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit       rdy, av, ls, tmo;
        bit [3:0] id;
        string    tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    rxirq_ctrl u_dut (
        .clk(clk), .rst(rst), .fifo_en(fen), .rx_ie(rie), .ls_ie(lie),
        .trig_level(trig), .fifo_level(lvl), .rx_push(push), .cpu_pop(pop),
        .rx_err(err), .char_tick(tick), .data_ready(rdy), .avail_irq(av),
        .ls_irq(ls), .tmo_irq(tmo), .irq(irq), .int_id(id)
    );

    // Driver: apply inputs on the falling edge, queue outputs due after the next rising edge
    task automatic step(input int l, input bit p, input bit r, input bit t, input bit e,
                        input bit xr, input bit xa, input bit xl, input bit xt,
                        input bit [3:0] xi, input string tag);
        exp_t x;
        lvl  = 5'(l);
        push = p;
        pop  = r;
        tick = t;
        err  = e;
        x.rdy = xr; x.av = xa; x.ls = xl; x.tmo = xt; x.id = xi; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
    endtask

    // Monitor: compare two ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t x;
                bit   xirq;
                x = q.pop_front();
                xirq = (x.id != 4'h1);
                checks++;
                if (rdy !== x.rdy || av !== x.av || ls !== x.ls || tmo !== x.tmo ||
                    id !== x.id || irq !== xirq) begin
                    fails++;
                    $display("FAIL %s: got rdy=%0b av=%0b ls=%0b tmo=%0b id=%h irq=%0b, expected rdy=%0b av=%0b ls=%0b tmo=%0b id=%h irq=%0b",
                             x.tag, rdy, av, ls, tmo, id, irq,
                             x.rdy, x.av, x.ls, x.tmo, x.id, xirq);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        step(0,0,0,0,0, 0,0,0,0,4'h1, "R1 reset");
        step(0,0,0,0,0, 0,0,0,0,4'h1, "R1 reset");
        rst = 1'b0;
        // R6 data ready
        step(0,1,0,0,0, 1,0,0,0,4'h1, "R6 push on empty sets");
        step(1,0,0,0,0, 1,0,0,0,4'h1, "R6 holds");
        // R7 timeout after four ticks
        for (int i = 0; i < 3; i++) step(1,0,0,1,0, 1,0,0,0,4'h1, "R7 under four ticks");
        step(1,0,0,1,0, 1,0,0,1,4'hC, "R7 fourth tick fires");
        // R9 push keeps, pop clears
        step(1,1,0,0,0, 1,0,0,1,4'hC, "R9 push keeps timeout");
        step(2,0,0,0,0, 1,0,0,1,4'hC, "R9 still pending");
        step(2,0,1,0,0, 1,0,0,0,4'h1, "R9 pop clears");
        // R8 restarts
        for (int i = 0; i < 3; i++) step(1,0,0,1,0, 1,0,0,0,4'h1, "R8 counting");
        step(1,1,0,0,0, 1,0,0,0,4'h1, "R8 push restarts");
        for (int i = 0; i < 3; i++) step(1,0,0,1,0, 1,0,0,0,4'h1, "R8 after push");
        step(1,0,1,0,0, 1,0,0,0,4'h1, "R8 pop restarts");
        for (int i = 0; i < 3; i++) step(1,0,0,1,0, 1,0,0,0,4'h1, "R8 after pop");
        step(1,0,0,1,0, 1,0,0,1,4'hC, "R8 fires after full count");
        step(1,0,1,0,0, 1,0,0,0,4'h1, "R9 pop clears again");
        // R10 empty holds timer
        step(0,0,0,0,0, 0,0,0,0,4'h1, "R6 clears on empty");
        for (int i = 0; i < 5; i++) step(0,0,0,1,0, 0,0,0,0,4'h1, "R10 ticks while empty");
        // R2 trigger compare
        step(3,1,0,0,0, 1,0,0,0,4'h1, "R2 below trigger");
        step(4,0,0,0,0, 1,1,0,0,4'h4, "R2 reaches trigger");
        step(5,0,0,0,0, 1,1,0,0,4'h4, "R2 above trigger");
        step(3,0,0,0,0, 1,0,0,0,4'h1, "R2 drops below");
        // R5 priority
        step(4,0,0,0,1, 1,1,1,0,4'h6, "R5 line over data");
        step(4,0,0,0,0, 1,1,0,0,4'h4, "R4 line follows error");
        for (int i = 0; i < 3; i++) step(4,0,0,1,0, 1,1,0,0,4'h4, "R7 counting with data");
        step(4,0,0,1,0, 1,1,0,1,4'h4, "R5 data over timeout");
        step(3,0,0,0,0, 1,0,0,1,4'hC, "R5 timeout alone");
        step(3,0,0,0,1, 1,0,1,1,4'h6, "R5 line over timeout");
        step(3,0,1,0,0, 1,0,0,0,4'h1, "R9 pop clears with line gone");
        // R3 enables gate receive requests
        rie = 1'b0;
        for (int i = 0; i < 4; i++) step(8,0,0,1,0, 1,0,0,0,4'h1, "R3 rx_ie low");
        fen = 1'b0; rie = 1'b1;
        step(8,0,0,0,0, 1,0,0,0,4'h1, "R3 fifo_en low");
        lie = 1'b0;
        step(8,0,0,0,1, 1,0,0,0,4'h1, "R4 line masked");
        fen = 1'b1; lie = 1'b1;
        step(8,0,1,0,0, 1,1,0,0,4'h4, "R3 enables restored");
        step(0,0,0,0,0, 0,0,0,0,4'h1, "R6 empty clears all");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule